// File: doc/BRIEF.md
# Fuse Program Request Gate

This block sits between a register front end and a one-time-programmable fuse array. Each request is one packed address that names a single fuse bit to burn. The block splits the address into its array, row and column fields. It maps the array select onto the physical arrays, since one array position has no array behind it. It then checks the request against a fixed sequence of permission conditions. A request that passes is forwarded as a one-cycle program strobe that carries the linear bit index. A request that fails is not forwarded, and the block records the first condition that stopped it.

Every attempt ends by setting a sticky done flag. The error flag is set when the request is rejected, or when the fuse array reports that the burn failed. It is cleared when an attempt succeeds. Both flags stay set until software clears them through the write-one-to-clear inputs. A cause code stays visible until the next attempt finishes, so firmware can tell which check blocked the request.

Top module: `efuse_pgm_gate`

## Requirements
- R1: The request address is split into three fields: array select in bits [12:11], row in bits [10:5] and column in bits [4:0]. The forwarded index is {mapped array, row, column}, which equals mapped_array*2048 + row*32 + column.
- R2: Array select 0 maps to 0, select 2 maps to 1 and select 3 maps to 2. Select 1 is rejected with cause code 1 (bad array).
- R3: A nonzero write-lock word rejects the request with cause code 2.
- R4: A program enable of 0 rejects the request with cause code 3.
- R5: The helper-data lock rejects requests to array selects 2 and 3, with cause code 4. It has no effect on array select 0.
- R6: The key lock rejects requests whose mapped array is 0 and whose row is between 24 and 31 inclusive, with cause code 5. Other rows are not affected.
- R7: When several conditions fail, the cause reported is the first one in this order: bad array, write lock, program disabled, helper lock, key lock.
- R8: An accepted request drives prog_strobe_o high for exactly the one cycle after its sampling edge, with the index on prog_idx_o. A rejected request produces no strobe.
- R9: After the sampling edge of a rejected request, done_o=1, err_o=1 and cause_o holds the rejection code.
- R10: One edge after an accepted strobe, done_o=1 and err_o equals array_fail_i as sampled during the strobe cycle. cause_o then reads 6 (array failure) or 0 (success).
- R11: done_o and err_o are sticky. Each is cleared by its own clear input. A new completion on the same edge takes precedence over the clear.
- R12: After reset, prog_strobe_o, prog_idx_o, done_o, err_o and cause_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Program request present this cycle |
| req_addr_i | input | 13 | Packed array/row/column address |
| wr_lock_i | input | LOCK_W | Global write-lock word; nonzero blocks programming |
| prog_en_i | input | 1 | Program enable from configuration |
| helper_lock_i | input | 1 | Helper-data store write lock |
| key_lock_i | input | 1 | Key-store row-range write lock |
| array_fail_i | input | 1 | Fuse array burn failure, valid during the strobe cycle |
| clr_done_i | input | 1 | Write-one-to-clear for done_o |
| clr_err_i | input | 1 | Write-one-to-clear for err_o |
| prog_strobe_o | output | 1 | One-cycle program command to the array |
| prog_idx_o | output | 13 | Linear bit index with the mapped array |
| done_o | output | 1 | Sticky attempt-finished flag |
| err_o | output | 1 | Sticky error flag |
| cause_o | output | 3 | Outcome code of the last finished attempt |

## Verification
The hardest case to reach is the one where several permission conditions fail at once. This is where the priority order decides the reported cause. It matters most on the rows at the edges of the key-store range, where one row either way changes the outcome. The stimulus reaches these cases by sweeping every array select and every row. For each address it uses two columns and all sixteen combinations of the lock and enable inputs, so every mix of failing conditions appears at every row boundary. Array failure is injected on a fixed arithmetic subset of the accepted requests.

// File: rtl/efp_pkg.sv
package efp_pkg;

    localparam int ARR_W  = 2;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 5;
    localparam int ADDR_W = ARR_W + ROW_W + COL_W;
    localparam int IDX_W  = ADDR_W;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_BAD_ARRAY  = 3'd1,
        CAUSE_LOCKED     = 3'd2,
        CAUSE_DISABLED   = 3'd3,
        CAUSE_HELPER     = 3'd4,
        CAUSE_KEY        = 3'd5,
        CAUSE_ARRAY_FAIL = 3'd6
    } cause_e;

    typedef struct packed {
        logic [ARR_W-1:0] arr;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } req_addr_t;

    typedef struct packed {
        logic             arr_ok;
        logic             helper_area;
        logic             key_area;
        logic [IDX_W-1:0] idx;
    } decoded_t;

    // Physical array behind a select value; select 1 has none.
    function automatic logic [ARR_W-1:0] map_array(input logic [ARR_W-1:0] sel);
        return (sel == '0) ? '0 : ARR_W'(sel - ARR_W'(1));
    endfunction

endpackage

// File: rtl/efp_decode.sv
module efp_decode
    import efp_pkg::*;
#(
    parameter int KEY_ROW_FIRST = 24,
    parameter int KEY_ROW_LAST  = 31
) (
    input  req_addr_t addr_i,
    output decoded_t  dec_o
);

    logic [ARR_W-1:0] mapped;
    logic             in_rows;

    always_comb begin
        mapped  = map_array(addr_i.arr);
        in_rows = (int'(addr_i.row) >= KEY_ROW_FIRST) &&
                  (int'(addr_i.row) <= KEY_ROW_LAST);

        dec_o             = '0;
        dec_o.idx         = {mapped, addr_i.row, addr_i.col};
        unique case (addr_i.arr)
            2'd0: begin
                dec_o.arr_ok   = 1'b1;
                dec_o.key_area = in_rows;
            end
            2'd2, 2'd3: begin
                dec_o.arr_ok      = 1'b1;
                dec_o.helper_area = 1'b1;
            end
            default: dec_o.arr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/efp_perm.sv
module efp_perm
    import efp_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  decoded_t          dec_i,
    input  logic [LOCK_W-1:0] wr_lock_i,
    input  logic              prog_en_i,
    input  logic              helper_lock_i,
    input  logic              key_lock_i,
    output cause_e            cause_o
);

    // First failing condition wins; CAUSE_NONE means forward.
    always_comb begin
        if (!dec_i.arr_ok)
            cause_o = CAUSE_BAD_ARRAY;
        else if (wr_lock_i != '0)
            cause_o = CAUSE_LOCKED;
        else if (!prog_en_i)
            cause_o = CAUSE_DISABLED;
        else if (helper_lock_i && dec_i.helper_area)
            cause_o = CAUSE_HELPER;
        else if (key_lock_i && dec_i.key_area)
            cause_o = CAUSE_KEY;
        else
            cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/efp_flags.sv
module efp_flags (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fin_i,
    input  logic fin_err_i,
    input  logic clr_done_i,
    input  logic clr_err_i,
    output logic done_o,
    output logic err_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            if (fin_i)
                done_o <= 1'b1;
            else if (clr_done_i)
                done_o <= 1'b0;

            if (fin_i)
                err_o <= fin_err_i;
            else if (clr_err_i)
                err_o <= 1'b0;
        end
    end

endmodule

// File: rtl/efuse_pgm_gate.sv
module efuse_pgm_gate
    import efp_pkg::*;
#(
    parameter int LOCK_W        = 16,
    parameter int KEY_ROW_FIRST = 24,
    parameter int KEY_ROW_LAST  = 31
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    input  logic [12:0]       req_addr_i,
    input  logic [LOCK_W-1:0] wr_lock_i,
    input  logic              prog_en_i,
    input  logic              helper_lock_i,
    input  logic              key_lock_i,
    input  logic              array_fail_i,
    input  logic              clr_done_i,
    input  logic              clr_err_i,
    output logic              prog_strobe_o,
    output logic [12:0]       prog_idx_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        cause_o
);

    decoded_t dec;
    cause_e   verdict;
    cause_e   cause_q;
    cause_e   fin_cause;
    logic     reject_now;
    logic     fin;
    logic     fin_err;
    logic     strobe_q;
    logic [IDX_W-1:0] idx_q;

    efp_decode #(
        .KEY_ROW_FIRST (KEY_ROW_FIRST),
        .KEY_ROW_LAST  (KEY_ROW_LAST)
    ) decode_i (
        .addr_i (req_addr_t'(req_addr_i)),
        .dec_o  (dec)
    );

    efp_perm #(
        .LOCK_W (LOCK_W)
    ) perm_i (
        .dec_i         (dec),
        .wr_lock_i     (wr_lock_i),
        .prog_en_i     (prog_en_i),
        .helper_lock_i (helper_lock_i),
        .key_lock_i    (key_lock_i),
        .cause_o       (verdict)
    );

    assign reject_now = req_valid_i && (verdict != CAUSE_NONE);

    // A rejection seen now outranks a strobe finishing on the same edge.
    always_comb begin
        fin       = reject_now || strobe_q;
        fin_err   = 1'b0;
        fin_cause = cause_q;
        if (reject_now) begin
            fin_err   = 1'b1;
            fin_cause = verdict;
        end else if (strobe_q) begin
            fin_err   = array_fail_i;
            fin_cause = array_fail_i ? CAUSE_ARRAY_FAIL : CAUSE_NONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            strobe_q <= 1'b0;
            idx_q    <= '0;
            cause_q  <= CAUSE_NONE;
        end else begin
            strobe_q <= req_valid_i && (verdict == CAUSE_NONE);
            if (req_valid_i && (verdict == CAUSE_NONE))
                idx_q <= dec.idx;
            if (fin)
                cause_q <= fin_cause;
        end
    end

    efp_flags flags_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fin_i      (fin),
        .fin_err_i  (fin_err),
        .clr_done_i (clr_done_i),
        .clr_err_i  (clr_err_i),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    assign prog_strobe_o = strobe_q;
    assign prog_idx_o    = strobe_q ? idx_q : '0;
    assign cause_o       = cause_q;

endmodule

// File: rtl/efp_checker.sv
module efp_checker #(
    parameter int LOCK_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              req_valid_i,
    input logic [12:0]       req_addr_i,
    input logic [LOCK_W-1:0] wr_lock_i,
    input logic              prog_en_i,
    input logic              helper_lock_i,
    input logic              clr_done_i,
    input logic              prog_strobe_o,
    input logic [12:0]       prog_idx_o,
    input logic              done_o,
    input logic              err_o
);

    assert_strobe_has_request_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_strobe_o |-> $past(req_valid_i));

    assert_strobe_unlocked_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_strobe_o |-> ($past(wr_lock_i) == '0));

    assert_strobe_enabled_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_strobe_o |-> $past(prog_en_i));

    assert_mapped_array_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_strobe_o |-> (prog_idx_o[12:11] != 2'd3));

    assert_helper_blocks_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && helper_lock_i && req_addr_i[12]) |=> !prog_strobe_o);

    assert_reject_flags_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && !prog_en_i) |=> (done_o && err_o && !prog_strobe_o));

    assert_done_after_strobe_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_strobe_o |=> done_o);

    assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !clr_done_i) |=> done_o);

endmodule

bind efuse_pgm_gate efp_checker #(.LOCK_W(LOCK_W)) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .req_valid_i   (req_valid_i),
    .req_addr_i    (req_addr_i),
    .wr_lock_i     (wr_lock_i),
    .prog_en_i     (prog_en_i),
    .helper_lock_i (helper_lock_i),
    .clr_done_i    (clr_done_i),
    .prog_strobe_o (prog_strobe_o),
    .prog_idx_o    (prog_idx_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/efuse_pgm_gate_tb_top.sv
module efuse_pgm_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic [15:0] wr_lock = '0;
    logic        prog_en = 1'b0;
    logic        helper_lock = 1'b0;
    logic        key_lock = 1'b0;
    logic        array_fail = 1'b0;
    logic        clr_done = 1'b0;
    logic        clr_err = 1'b0;
    logic        strobe;
    logic [12:0] idx;
    logic        done;
    logic        err;
    logic [2:0]  cause;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    efuse_pgm_gate dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .req_valid_i   (req_valid),
        .req_addr_i    (req_addr),
        .wr_lock_i     (wr_lock),
        .prog_en_i     (prog_en),
        .helper_lock_i (helper_lock),
        .key_lock_i    (key_lock),
        .array_fail_i  (array_fail),
        .clr_done_i    (clr_done),
        .clr_err_i     (clr_err),
        .prog_strobe_o (strobe),
        .prog_idx_o    (idx),
        .done_o        (done),
        .err_o         (err),
        .cause_o       (cause)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_cause(int a, int r, int wl, int pe, int hl, int kl);
        if (a == 1) return 1;
        if (wl != 0) return 2;
        if (pe == 0) return 3;
        if (a >= 2 && hl != 0) return 4;
        if (a == 0 && kl != 0 && r >= 24 && r <= 31) return 5;
        return 0;
    endfunction

    function automatic int fail_count(int a, int r, int wl, int pe, int hl, int kl);
        int n = 0;
        if (a == 1) n++;
        if (wl != 0) n++;
        if (pe == 0) n++;
        if (a >= 2 && hl != 0) n++;
        if (a == 0 && kl != 0 && r >= 24 && r <= 31) n++;
        return n;
    endfunction

    function automatic string cause_tag(int c, int nf);
        if (nf > 1) return "R7";
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_done = 1'b1;
        clr_err  = 1'b1;
        tick();
        clr_done = 1'b0;
        clr_err  = 1'b0;
    endtask

    task automatic one_request(int a, int r, int c, int wl, int pe, int hl, int kl, int fl);
        int ec;
        int nf;
        int eidx;
        string tg;
        ec   = exp_cause(a, r, wl, pe, hl, kl);
        nf   = fail_count(a, r, wl, pe, hl, kl);
        eidx = ((a == 0) ? 0 : a - 1) * 2048 + r * 32 + c;
        tg   = cause_tag(ec, nf);
        req_addr    = 13'(a * 2048 + r * 32 + c);
        wr_lock     = 16'(wl);
        prog_en     = pe[0];
        helper_lock = hl[0];
        key_lock    = kl[0];
        req_valid   = 1'b1;
        tick();
        req_valid = 1'b0;
        if (ec != 0) begin
            chk(tg, "no strobe on reject", int'(strobe), 0);
            chk("R9", "done on reject", int'(done), 1);
            chk("R9", "err on reject", int'(err), 1);
            chk(tg, "reject cause", int'(cause), ec);
        end else begin
            chk("R8", "strobe on accept", int'(strobe), 1);
            chk("R1", "bit index", int'(idx), eidx);
            chk("R10", "done not yet set", int'(done), 0);
            array_fail = fl[0];
            tick();
            array_fail = 1'b0;
            chk("R8", "strobe one cycle", int'(strobe), 0);
            chk("R10", "done after strobe", int'(done), 1);
            chk("R10", "err from array", int'(err), fl);
            chk("R10", "completion cause", int'(cause), fl ? 6 : 0);
        end
        clear_flags();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R12: values right after reset
        chk("R12", "strobe reset", int'(strobe), 0);
        chk("R12", "idx reset", int'(idx), 0);
        chk("R12", "done reset", int'(done), 0);
        chk("R12", "err reset", int'(err), 0);
        chk("R12", "cause reset", int'(cause), 0);

        // Sweep: every array select and row, two columns, all lock mixes
        for (int a = 0; a < 4; a++) begin
            for (int r = 0; r < 64; r++) begin
                for (int cs = 0; cs < 2; cs++) begin
                    for (int m = 0; m < 16; m++) begin
                        int c;
                        int wl;
                        int fl;
                        c  = (cs == 0) ? 31 : ((r % 32) ^ 5);
                        wl = m[0] ? (1 << (r % 16)) : 0;
                        fl = (((r + c + m) % 7) == 0) ? 1 : 0;
                        one_request(a, r, c, wl, int'(m[1]), int'(m[2]), int'(m[3]), fl);
                    end
                end
            end
        end

        // R11: flags hold without clear, clear independently
        one_request(1, 3, 3, 0, 1, 0, 0, 0);
        req_valid = 1'b1;
        req_addr  = 13'(1 * 2048);
        tick();
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk("R11", "done held", int'(done), 1);
        chk("R11", "err held", int'(err), 1);
        clr_done = 1'b1;
        tick();
        clr_done = 1'b0;
        chk("R11", "done cleared", int'(done), 0);
        chk("R11", "err kept by done clear", int'(err), 1);
        clr_err = 1'b1;
        tick();
        clr_err = 1'b0;
        chk("R11", "err cleared", int'(err), 0);

        // R11: completion on the same edge as a clear wins
        req_valid = 1'b1;
        req_addr  = 13'(1 * 2048);
        clr_done  = 1'b1;
        clr_err   = 1'b1;
        tick();
        req_valid = 1'b0;
        clr_done  = 1'b0;
        clr_err   = 1'b0;
        chk("R11", "set beats clear done", int'(done), 1);
        chk("R11", "set beats clear err", int'(err), 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule